// File: doc/BRIEF.md
# I2C Standby Wakeup Detector

This block watches the two I2C bus lines while a low-power system sleeps and raises a wakeup interrupt request when a transfer begins. A transfer start is recognised as a high-to-low transition on SDA while SCL stays high. Both lines are first brought into the local clock domain through a short chain of flip-flops. Firmware arms the detector with an enable bit shortly before standby. After every exit from standby, whatever woke the system, firmware must clear that enable bit before normal I2C operation can resume.

The block also records whether the bus was busy at the moment standby began. The I2C controller's state cannot progress while the system sleeps, so a transfer that was in flight cannot finish. A start seen in that situation is therefore flagged as a bus error rather than a wakeup. While standby is active, a hold-enable output tells the I2C controller to keep its status flags, protocol state and bus output levels unchanged. Oscillator start-up is outside this block: the first data bit is expected no earlier than a stabilisation interval of at least 100 µs after the wakeup edge, and bits arriving before that are not buffered.

Top module: `i2c_wake_det`

## Requirements
- R1: After reset, `wake_irq_o`, `bus_err_o` and `hold_o` are all 0.
- R2: A falling edge on `sda_i` while `scl_i` is high, with `wake_en_i` = 1, sets `wake_irq_o`. The flag rises on the (SYNC_STAGES+1)-th rising clock edge after the pin change and not earlier.
- R3: With `wake_en_i` = 0, a falling edge on `sda_i` leaves `wake_irq_o` at 0.
- R4: An SDA falling edge while SCL is low, an SCL rising edge while SDA is low, and an SDA rising edge all leave `wake_irq_o` at 0.
- R5: `wake_irq_o` is sticky. It stays 1 until `wake_clr_i` is 1 at a rising edge, which clears it on that edge.
- R6: `wake_en_i` = 0 at a rising edge clears `wake_irq_o` on that edge.
- R7: The busy flag is captured at standby entry. If `busy_i` was 1 in the cycle before `standby_i` rose, a start detected during standby sets `bus_err_o` and leaves `wake_irq_o` at 0.
- R8: While `standby_i` is 1, changes on `busy_i` are ignored. A start during a standby entered with the bus idle raises `wake_irq_o` and not `bus_err_o`, even if `busy_i` became 1 during standby.
- R9: `hold_o` rises on the first rising edge after `standby_i` becomes 1 and falls on the first rising edge after `standby_i` returns to 0.
- R10: If a wakeup is detected in the same cycle as `wake_clr_i` = 1, the set wins and `wake_irq_o` becomes 1.
- R11: `bus_err_o` is sticky. It stays 1 after standby ends until `err_clr_i` is 1 at a rising edge, which clears it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| sda_i | input | 1 | Raw I2C data line |
| scl_i | input | 1 | Raw I2C clock line |
| wake_en_i | input | 1 | Wakeup enable bit from firmware |
| wake_clr_i | input | 1 | Firmware write of 0 to the wakeup flag |
| err_clr_i | input | 1 | Firmware clear of the bus error flag |
| standby_i | input | 1 | System standby is active |
| busy_i | input | 1 | Bus-busy flag from the I2C controller |
| wake_irq_o | output | 1 | Sticky wakeup interrupt request |
| bus_err_o | output | 1 | Sticky bus error indication |
| hold_o | output | 1 | Freeze enable for the I2C controller state |

## Verification
The bench builds the block with SYNC_STAGES = 2. It derives the start-to-flag latency of three edges from that value. With this setting it can check that the flag is still low one edge before it is due and high on the edge it is due, which pins down the synchroniser depth exactly. It also makes it practical to place a clear pulse in the very cycle a start is decoded. The standby scenarios change `busy_i` in both directions after entry. This separates a flag captured at entry from one that tracks the live input.

// File: rtl/i2c_wake_pkg.sv
package i2c_wake_pkg;
  localparam int LINE_W  = 2;
  localparam int SDA_IDX = 0;
  localparam int SCL_IDX = 1;
  // idle bus level is high on both lines
  localparam logic [LINE_W-1:0] LINE_IDLE = '1;
endpackage

// File: rtl/i2c_wake_sync.sv
module i2c_wake_sync #(
  parameter int WIDTH = 2,
  parameter int STAGES = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  for (genvar b = 0; b < WIDTH; b++) begin : g_bit
    logic [STAGES-1:0] chain_q;
    logic [STAGES-1:0] chain_d;

    always_comb chain_d = {chain_q[STAGES-2:0], d_i[b]};

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) chain_q <= {STAGES{RST_VAL[b]}};
      else         chain_q <= chain_d;
    end

    assign q_o[b] = chain_q[STAGES-1];
  end
endmodule

// File: rtl/i2c_wake_start_det.sv
module i2c_wake_start_det (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sda_s_i,
  input  logic scl_s_i,
  output logic start_o
);
  logic sda_prev_q;
  logic sda_prev_d;

  always_comb begin
    sda_prev_d = sda_s_i;
    // high-to-low on data while the clock line stays high
    start_o    = sda_prev_q & ~sda_s_i & scl_s_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sda_prev_q <= 1'b1;
    else         sda_prev_q <= sda_prev_d;
  end
endmodule

// File: rtl/i2c_wake_flags.sv
module i2c_wake_flags (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic wake_en_i,
  input  logic wake_clr_i,
  input  logic err_clr_i,
  input  logic standby_i,
  input  logic busy_i,
  output logic wake_o,
  output logic err_o
);
  logic busy_q, busy_d, busy_ce;
  logic wake_q, wake_d, wake_ce;
  logic err_q, err_d, err_ce;
  logic err_cond, wake_set, wake_drop, err_set;

  always_comb begin
    // busy follows the controller outside standby and freezes inside it
    busy_ce   = ~standby_i;
    busy_d    = busy_i;

    err_cond  = standby_i & busy_q;
    wake_set  = start_i & wake_en_i & ~err_cond;
    err_set   = start_i & err_cond;
    wake_drop = wake_clr_i | ~wake_en_i;

    wake_ce   = wake_set | wake_drop;
    wake_d    = wake_set;          // set has priority over clear
    err_ce    = err_set | err_clr_i;
    err_d     = err_set;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      busy_q <= 1'b0;
    else if (busy_ce) busy_q <= busy_d;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      wake_q <= 1'b0;
    else if (wake_ce) wake_q <= wake_d;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     err_q <= 1'b0;
    else if (err_ce) err_q <= err_d;
  end

  assign wake_o = wake_q;
  assign err_o  = err_q;
endmodule

// File: rtl/i2c_wake_det.sv
module i2c_wake_det
  import i2c_wake_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sda_i,
  input  logic scl_i,
  input  logic wake_en_i,
  input  logic wake_clr_i,
  input  logic err_clr_i,
  input  logic standby_i,
  input  logic busy_i,
  output logic wake_irq_o,
  output logic bus_err_o,
  output logic hold_o
);
  logic [LINE_W-1:0] lines_raw;
  logic [LINE_W-1:0] lines_s;
  logic              start;
  logic              hold_q, hold_d;

  always_comb begin
    lines_raw          = '0;
    lines_raw[SDA_IDX] = sda_i;
    lines_raw[SCL_IDX] = scl_i;
  end

  i2c_wake_sync #(
    .WIDTH  (LINE_W),
    .STAGES (SYNC_STAGES),
    .RST_VAL(LINE_IDLE)
  ) i_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (lines_raw),
    .q_o   (lines_s)
  );

  i2c_wake_start_det i_start (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .sda_s_i(lines_s[SDA_IDX]),
    .scl_s_i(lines_s[SCL_IDX]),
    .start_o(start)
  );

  i2c_wake_flags i_flags (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .start_i   (start),
    .wake_en_i (wake_en_i),
    .wake_clr_i(wake_clr_i),
    .err_clr_i (err_clr_i),
    .standby_i (standby_i),
    .busy_i    (busy_i),
    .wake_o    (wake_irq_o),
    .err_o     (bus_err_o)
  );

  always_comb hold_d = standby_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) hold_q <= 1'b0;
    else         hold_q <= hold_d;
  end

  assign hold_o = hold_q;
endmodule

// File: rtl/i2c_wake_det_chk.sv
module i2c_wake_det_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic wake_en_i,
  input logic wake_clr_i,
  input logic err_clr_i,
  input logic standby_i,
  input logic wake_irq_o,
  input logic bus_err_o,
  input logic hold_o
);
  p_rise_needs_en_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(wake_irq_o) |-> $past(wake_en_i));

  p_wake_sticky_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wake_irq_o && !wake_clr_i && wake_en_i) |=> wake_irq_o);

  p_en_low_clears_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wake_en_i |=> !wake_irq_o);

  p_err_in_standby_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(bus_err_o) |-> ($past(standby_i) && !$rose(wake_irq_o)));

  p_hold_on_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    standby_i |=> hold_o);

  p_hold_off_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !standby_i |=> !hold_o);

  p_err_sticky_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_err_o && !err_clr_i) |=> bus_err_o);
endmodule

bind i2c_wake_det i2c_wake_det_chk i_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .wake_en_i (wake_en_i),
  .wake_clr_i(wake_clr_i),
  .err_clr_i (err_clr_i),
  .standby_i (standby_i),
  .wake_irq_o(wake_irq_o),
  .bus_err_o (bus_err_o),
  .hold_o    (hold_o)
);

// File: tb/test_i2c_wake_det.sv
`timescale 1ns/1ps
module test_i2c_wake_det;
  localparam int STAGES = 2;
  localparam int LAT    = STAGES + 1;

  typedef struct {
    logic  irq;
    logic  err;
    logic  hold;
    string tag;
  } exp_t;

  logic clk = 1'b0;
  logic rst_n, sda, scl, wen, wclr, eclr, stby, busy;
  logic irq, err, hold;
  int   checks = 0;
  int   errors = 0;
  bit   done = 0;
  exp_t exp_q[$];

  always #4 clk = ~clk;

  i2c_wake_det #(.SYNC_STAGES(STAGES)) i_i2c_wake_det (
    .clk_i(clk), .rst_ni(rst_n), .sda_i(sda), .scl_i(scl),
    .wake_en_i(wen), .wake_clr_i(wclr), .err_clr_i(eclr),
    .standby_i(stby), .busy_i(busy),
    .wake_irq_o(irq), .bus_err_o(err), .hold_o(hold)
  );

  // monitor: compares outputs against queued expectations at the falling edge
  always @(negedge clk) begin
    if (exp_q.size() != 0) begin
      exp_t e;
      e = exp_q.pop_front();
      checks++;
      if (irq !== e.irq || err !== e.err || hold !== e.hold) begin
        errors++;
        $display("FAIL %s: got irq=%b err=%b hold=%b, expected irq=%b err=%b hold=%b",
                 e.tag, irq, err, hold, e.irq, e.err, e.hold);
      end
    end
  end

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
  endtask

  // driver side: queue an expectation just after an edge, resume at the falling edge
  task automatic expect_out(input logic i, input logic e, input logic h, input string tag);
    exp_t x;
    #1;
    x.irq = i; x.err = e; x.hold = h; x.tag = tag;
    exp_q.push_back(x);
    @(negedge clk);
  endtask

  initial begin
    rst_n = 0; sda = 1; scl = 1; wen = 0; wclr = 0; eclr = 0; stby = 0; busy = 0;
    tick(4);
    @(negedge clk) rst_n = 1;
    tick(1); expect_out(0, 0, 0, "R1 reset state");

    // R2: start with enable, exact latency
    wen = 1; tick(2); @(negedge clk);
    sda = 0;
    tick(LAT - 1); expect_out(0, 0, 0, "R2 not before latency");
    tick(1); expect_out(1, 0, 0, "R2 wake after latency");
    sda = 1; tick(4); @(negedge clk);

    // R5: sticky, then clear pulse
    tick(5); expect_out(1, 0, 0, "R5 flag held");
    wclr = 1; tick(1); expect_out(0, 0, 0, "R5 cleared by write");
    wclr = 0;

    // R4: SCL low during SDA fall, SCL rise with SDA low, SDA rise
    scl = 0; tick(4); @(negedge clk);
    sda = 0; tick(4); expect_out(0, 0, 0, "R4 SDA fall with SCL low");
    scl = 1; tick(4); expect_out(0, 0, 0, "R4 SCL rise with SDA low");
    sda = 1; tick(4); expect_out(0, 0, 0, "R4 SDA rise");

    // R3: enable low blocks wakeup
    wen = 0; tick(1); @(negedge clk);
    sda = 0; tick(LAT + 1); expect_out(0, 0, 0, "R3 disabled start ignored");
    sda = 1; tick(4); @(negedge clk);

    // R6: dropping enable clears the flag
    wen = 1; tick(1); @(negedge clk);
    sda = 0; tick(LAT); expect_out(1, 0, 0, "R6 flag set first");
    sda = 1; wen = 0; tick(1); expect_out(0, 0, 0, "R6 enable low clears");
    wen = 1; tick(4); @(negedge clk);

    // R10: set beats a simultaneous clear
    sda = 0; tick(LAT - 1); @(negedge clk);
    wclr = 1; tick(1); expect_out(1, 0, 0, "R10 set wins over clear");
    wclr = 0; sda = 1; tick(1); @(negedge clk);
    wclr = 1; tick(1); expect_out(0, 0, 0, "R10 cleanup clear");
    wclr = 0; tick(4); @(negedge clk);

    // R9 + R7: standby entered with bus busy
    busy = 1; tick(1); @(negedge clk);
    stby = 1; tick(1); expect_out(0, 0, 1, "R9 hold after entry");
    busy = 0; tick(2); @(negedge clk);
    sda = 0; tick(LAT); expect_out(0, 1, 1, "R7 start gives bus error");
    sda = 1; tick(4); @(negedge clk);
    stby = 0; tick(1); expect_out(0, 1, 0, "R9 hold released / R11 error kept");
    tick(3); expect_out(0, 1, 0, "R11 error sticky");
    eclr = 1; tick(1); expect_out(0, 0, 0, "R11 error cleared");
    eclr = 0; tick(2); @(negedge clk);

    // R8: standby entered idle, busy rises during standby
    stby = 1; tick(2); @(negedge clk);
    busy = 1; tick(2); @(negedge clk);
    sda = 0; tick(LAT); expect_out(1, 0, 1, "R8 busy during standby ignored");
    sda = 1; stby = 0; busy = 0; tick(1); expect_out(1, 0, 0, "R8 exit keeps wake flag");
    wen = 0; tick(1); expect_out(0, 0, 0, "R8 firmware clears enable on exit");

    tick(3);
    if (!done) begin
      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog: got timeout, expected completion");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule